// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether an I/O access may proceed once the privilege comparison has handed the decision to the per-task port bitmap. The access gives a 16-bit port number and a size of one, two or four bytes. The map is located by a 16-bit base offset and bounded by a 16-bit segment limit. Every port number stands for one bit of the map. The checker fetches the one or two map bytes that hold the tested bits through a byte-wide read port with a request/valid handshake. It then pulses `done` with exactly one of `allow` or `fault`.

Any part of the map that lies past the segment limit is treated as set bits, and no read is issued for it. An access with no map, with an illegal size code, or whose port range runs past the top of the port space is refused without touching memory. While a decision is in progress, new start strobes are ignored.

Top module: `port_perm_checker`

## Requirements
- R1: Port p owns bit (p mod 8) of the map byte at byte offset base + floor(p/8); `rd_addr` (17 bits) carries that offset without truncation.
- R2: `acc_size` code 0 tests port p only, code 1 tests p and p+1, code 2 tests p through p+3; code 3 is illegal and faults with no read.
- R3: The verdict is fault when any tested bit is 1 and allow only when every tested bit is 0; untested bits of a fetched byte have no effect.
- R4: A map byte whose offset is greater than `seg_limit` counts as all ones, and no read is ever issued for such an offset.
- R5: When `map_base` >= `seg_limit` every access faults and no read is issued.
- R6: When p + size - 1 exceeds 0xFFFF the access faults and no read is issued.
- R7: When the tested bits span two bytes, the lower offset is read first and the next offset (lower + 1) second; if the first byte already holds a tested 1, the second byte is not read.
- R8: `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen; `rd_valid` has no effect while `rd_req` is low.
- R9: `done` is high for exactly one cycle per accepted start, and `allow`/`fault` are high only in that cycle, exactly one of them.
- R10: `start` is ignored from the cycle after it is accepted through the `done` cycle; the verdict depends only on the inputs present when start was accepted.
- R11: After reset `done`, `allow`, `fault` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check, sampled while idle |
| port_addr | input | 16 | First port number of the access |
| acc_size | input | 2 | Size code: 0 byte, 1 word, 2 doubleword, 3 illegal |
| map_base | input | 16 | Byte offset of the bitmap inside the segment |
| seg_limit | input | 16 | Last valid byte offset of the segment |
| rd_req | output | 1 | Map byte read request |
| rd_addr | output | 17 | Byte offset being read |
| rd_valid | input | 1 | Read data present this cycle |
| rd_data | input | 8 | Map byte returned |
| done | output | 1 | One-cycle verdict strobe |
| allow | output | 1 | Access permitted, valid with done |
| fault | output | 1 | Access refused, valid with done |

## Verification
The bench builds the checker at its default 16-bit port width, which makes the top of the port space reachable, so the wrap refusal can be tested next to ordinary ports. The bench memory answers after a random 0 to 3 cycles of latency. This lets held requests, back-to-back reads of two bytes, and start strobes arriving mid-fetch all occur. Small random bases and limits put the limit edge inside almost every run, so refused bytes past the limit and maps that are present only in part are exercised often.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH0 = 2'd1,
        ST_FETCH1 = 2'd2,
        ST_DONE   = 2'd3
    } ppc_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } ppc_size_e;

    localparam int BYTE_BITS = 8;
    localparam int BIT_SEL_W = 3;
endpackage

// File: rtl/ppc_span.sv
module ppc_span
    import ppc_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int OFF_W  = PORT_W + 1
) (
    input  logic [PORT_W-1:0]    port,
    input  logic [1:0]           size_code,
    input  logic [PORT_W-1:0]    base,
    input  logic [PORT_W-1:0]    limit,
    output logic [OFF_W-1:0]     off0,
    output logic [BYTE_BITS-1:0] mask0,
    output logic [BYTE_BITS-1:0] mask1,
    output logic                 need2,
    output logic                 beyond0,
    output logic                 beyond1,
    output logic                 reject
);
    localparam int SPAN_W = 2 * BYTE_BITS;

    logic [2:0]        nbytes;
    logic [PORT_W:0]   last_port;
    logic [3:0]        ones;
    logic [SPAN_W-1:0] span;
    logic [OFF_W-1:0]  off1;
    logic [OFF_W-1:0]  lim_x;
    logic              bad_size;
    logic              wrap;
    logic              nomap;

    always_comb begin
        case (ppc_size_e'(size_code))
            SZ_BYTE:  nbytes = 3'd1;
            SZ_WORD:  nbytes = 3'd2;
            SZ_DWORD: nbytes = 3'd4;
            default:  nbytes = 3'd0;
        endcase
    end

    assign bad_size  = (nbytes == 3'd0);
    assign last_port = {1'b0, port} + {{(PORT_W-2){1'b0}}, nbytes} - (PORT_W+1)'(1);
    assign wrap      = last_port[PORT_W];
    assign nomap     = (base >= limit);
    assign reject    = bad_size | wrap | nomap;

    assign off0  = {1'b0, base} + OFF_W'(port >> BIT_SEL_W);
    assign off1  = off0 + OFF_W'(1);
    assign lim_x = {1'b0, limit};

    assign beyond0 = (off0 > lim_x);
    assign beyond1 = (off1 > lim_x);

    assign ones  = 4'((5'd1 << nbytes) - 5'd1);
    assign span  = {{(SPAN_W-4){1'b0}}, ones} << port[BIT_SEL_W-1:0];
    assign mask0 = span[BYTE_BITS-1:0];
    assign mask1 = span[SPAN_W-1:BYTE_BITS];
    assign need2 = |mask1;
endmodule

// File: rtl/ppc_core.sv
module ppc_core
    import ppc_pkg::*;
#(
    parameter int OFF_W = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [OFF_W-1:0]     off0,
    input  logic [BYTE_BITS-1:0] mask0,
    input  logic [BYTE_BITS-1:0] mask1,
    input  logic                 need2,
    input  logic                 beyond0,
    input  logic                 beyond1,
    input  logic                 reject,
    output logic                 rd_req,
    output logic [OFF_W-1:0]     rd_addr,
    input  logic                 rd_valid,
    input  logic [BYTE_BITS-1:0] rd_data,
    output logic                 done,
    output logic                 allow,
    output logic                 fault
);
    typedef struct packed {
        ppc_state_e           st;
        logic [OFF_W-1:0]     addr;
        logic [BYTE_BITS-1:0] mask;
        logic [BYTE_BITS-1:0] mask_hi;
        logic                 more;
        logic                 far_hi;
        logic                 fault;
    } core_regs_t;

    core_regs_t r_q, r_d;
    logic       hit;

    assign hit = |(rd_data & r_q.mask);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (reject || beyond0) begin
                        r_d.st    = ST_DONE;
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.st      = ST_FETCH0;
                        r_d.addr    = off0;
                        r_d.mask    = mask0;
                        r_d.mask_hi = mask1;
                        r_d.more    = need2;
                        r_d.far_hi  = beyond1;
                        r_d.fault   = 1'b0;
                    end
                end
            end
            ST_FETCH0: begin
                if (rd_valid) begin
                    if (hit) begin
                        r_d.st    = ST_DONE;
                        r_d.fault = 1'b1;
                    end else if (r_q.more && r_q.far_hi) begin
                        r_d.st    = ST_DONE;
                        r_d.fault = 1'b1;
                    end else if (r_q.more) begin
                        r_d.st   = ST_FETCH1;
                        r_d.addr = r_q.addr + OFF_W'(1);
                        r_d.mask = r_q.mask_hi;
                    end else begin
                        r_d.st    = ST_DONE;
                        r_d.fault = 1'b0;
                    end
                end
            end
            ST_FETCH1: begin
                if (rd_valid) begin
                    r_d.st    = ST_DONE;
                    r_d.fault = hit;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req  = (r_q.st == ST_FETCH0) || (r_q.st == ST_FETCH1);
    assign rd_addr = r_q.addr;
    assign done    = (r_q.st == ST_DONE);
    assign allow   = done & ~r_q.fault;
    assign fault   = done & r_q.fault;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !rd_req)); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R8

    AST_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (!rd_req || rd_addr == $past(rd_addr) + OFF_W'(1))); // R7

    AST_REJECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start && reject) |=> (fault && !rd_req)); // R5

    AST_FAR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start && beyond0) |=> (fault && !rd_req)); // R4
endmodule

// File: rtl/port_perm_checker.sv
module port_perm_checker
    import ppc_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int OFF_W  = PORT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PORT_W-1:0]    port_addr,
    input  logic [1:0]           acc_size,
    input  logic [PORT_W-1:0]    map_base,
    input  logic [PORT_W-1:0]    seg_limit,
    output logic                 rd_req,
    output logic [OFF_W-1:0]     rd_addr,
    input  logic                 rd_valid,
    input  logic [BYTE_BITS-1:0] rd_data,
    output logic                 done,
    output logic                 allow,
    output logic                 fault
);
    logic [OFF_W-1:0]     off0;
    logic [BYTE_BITS-1:0] mask0, mask1;
    logic                 need2, beyond0, beyond1, reject;

    ppc_span #(.PORT_W(PORT_W), .OFF_W(OFF_W)) span_i (
        .port      (port_addr),
        .size_code (acc_size),
        .base      (map_base),
        .limit     (seg_limit),
        .off0      (off0),
        .mask0     (mask0),
        .mask1     (mask1),
        .need2     (need2),
        .beyond0   (beyond0),
        .beyond1   (beyond1),
        .reject    (reject)
    );

    ppc_core #(.OFF_W(OFF_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .off0     (off0),
        .mask0    (mask0),
        .mask1    (mask1),
        .need2    (need2),
        .beyond0  (beyond0),
        .beyond1  (beyond1),
        .reject   (reject),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .done     (done),
        .allow    (allow),
        .fault    (fault)
    );
endmodule

// File: tb/port_perm_checker_tb_top.sv
module port_perm_checker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] port_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [15:0] map_base = '0;
    logic [15:0] seg_limit = '0;
    logic        rd_req;
    logic [16:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        done, allow, fault;

    int checks = 0;
    int errors = 0;

    logic [7:0] bm [256];
    int lat_max = 0;
    int lat_cnt = 0;
    int nreads = 0;
    int first_addr = -1;
    int second_addr = -1;
    int cur_limit = 0;
    int far_reads = 0;
    int cyc = 0;

    port_perm_checker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .port_addr(port_addr),
        .acc_size(acc_size), .map_base(map_base), .seg_limit(seg_limit),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .allow(allow), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
    end

    // Bench memory: answers a held request after a random latency.
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid = 1'b0;
            lat_cnt  = 0;
        end else if (rd_req) begin
            if (lat_cnt >= lat_max) begin
                rd_valid = 1'b1;
                rd_data  = bm[rd_addr[7:0]];
                if (nreads == 0) first_addr = int'(rd_addr);
                if (nreads == 1) second_addr = int'(rd_addr);
                if (int'(rd_addr) > cur_limit) far_reads++;
                nreads++;
                lat_cnt = 0;
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected verdict and read trace from the requirements.
    function automatic void model(input int p, input int code, input int base, input int lim,
                                  output bit f, output int nr, output int a0);
        int n;
        n  = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 0;
        f  = 1'b0;
        nr = 0;
        a0 = base + (p >> 3);
        if (n == 0 || base >= lim || p + n - 1 > 65535) begin
            f = 1'b1;
            return;
        end
        for (int b = p >> 3; b <= (p + n - 1) >> 3; b++) begin
            int off;
            logic [7:0] v;
            off = base + b;
            if (off > lim) begin
                f = 1'b1;
                return;
            end
            nr++;
            v = bm[off & 255];
            for (int i = 0; i < 8; i++) begin
                int q;
                q = b * 8 + i;
                if (q >= p && q <= p + n - 1 && v[i]) f = 1'b1;
            end
            if (f) return;
        end
    endfunction

    task automatic run(input int p, input int code, input int base, input int lim,
                       input bit poke, input string tag);
        bit ef;
        int enr, ea0, waited;
        bit seen;
        model(p, code, base, lim, ef, enr, ea0);
        @(negedge clk);
        nreads = 0; first_addr = -1; second_addr = -1; far_reads = 0;
        cur_limit = lim;
        start = 1'b1;
        port_addr = p[15:0]; acc_size = code[1:0];
        map_base = base[15:0]; seg_limit = lim[15:0];
        @(negedge clk);
        if (poke) begin
            // R10: a second strobe with different inputs while busy
            start = 1'b1;
            port_addr = ~p[15:0]; acc_size = 2'd3;
            map_base = 16'd0; seg_limit = 16'hFFFF;
        end else begin
            start = 1'b0;
        end
        seen = 1'b0;
        waited = 0;
        while (!seen && waited < 200) begin
            if (waited == 1) start = 1'b0;
            if (done) seen = 1'b1;
            else begin
                @(negedge clk);
                waited++;
            end
        end
        start = 1'b0;
        if (!seen) begin
            check(1'b0, "R9 watchdog no done", 0, 1);
            return;
        end
        check(fault == ef, {tag, " R3 fault verdict"}, int'(fault), int'(ef));
        check(allow == !ef, {tag, " R9 allow verdict"}, int'(allow), int'(!ef));
        check(nreads == enr, {tag, " R7 read count"}, nreads, enr);
        check(far_reads == 0, {tag, " R4 read past limit"}, far_reads, 0);
        if (enr > 0) check(first_addr == ea0, {tag, " R1 first offset"}, first_addr, ea0);
        if (enr > 1) check(second_addr == ea0 + 1, {tag, " R7 second offset"}, second_addr, ea0 + 1);
        @(negedge clk);
        check(!done && !allow && !fault, {tag, " R9 single pulse"}, int'(done), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        check(1'b0, "watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) bm[i] = 8'($urandom & $urandom & $urandom);

        repeat (3) @(negedge clk);
        // R11: reset state
        check(!done && !allow && !fault && !rd_req, "R11 reset outputs", int'(done | rd_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !rd_req, "R11 idle after reset", int'(done | rd_req), 0);

        // R8: rd_valid while no request has no effect
        rd_valid = 1'b1; rd_data = 8'hFF;
        @(negedge clk);
        rd_valid = 1'b0;
        check(!done && !rd_req, "R8 stray valid ignored", int'(done | rd_req), 0);

        lat_max = 2;
        // R1: port 41, base 10 -> offset 15 bit 1
        bm[15] = 8'h02; run(41, 0, 10, 60, 0, "R1 port41 set");
        bm[15] = 8'hFD; run(41, 0, 10, 60, 0, "R3 port41 neighbours set");
        // R7/R2: dword straddle 14..17
        bm[1] = 8'h00; bm[2] = 8'h02; run(14, 2, 0, 100, 0, "R7 straddle hit high");
        bm[2] = 8'h04; run(14, 2, 0, 100, 0, "R2 straddle clear");
        bm[1] = 8'h40; run(14, 2, 0, 100, 0, "R7 early stop");
        // R4: limit = base + 31 maps ports 0..255
        bm[31] = 8'h00; run(255, 0, 0, 31, 0, "R4 last mapped port");
        run(256, 0, 0, 31, 0, "R4 first unmapped port");
        run(254, 2, 0, 31, 0, "R4 straddle past limit");
        // R5: no map
        run(3, 0, 50, 50, 0, "R5 base equals limit");
        run(3, 0, 70, 50, 0, "R5 base above limit");
        // R6: wrap past top of port space
        run(16'hFFFE, 2, 0, 16'hFFFF, 0, "R6 dword wrap");
        run(16'hFFFF, 1, 0, 16'hFFFF, 0, "R6 word wrap");
        // R2: illegal size code
        run(5, 3, 0, 100, 0, "R2 size code 3");
        // R10: poke during a fetch and during a direct refusal
        run(41, 0, 10, 60, 1, "R10 poke while fetching");
        run(3, 0, 50, 50, 1, "R10 poke while refusing");

        for (int t = 0; t < NRAND; t++) begin
            int base, lim, p, code, sel;
            lat_max = int'($urandom % 4);
            base = int'($urandom % 200);
            sel  = int'($urandom % 8);
            lim  = (sel == 0) ? int'($urandom % 256) : base + int'($urandom % 40);
            p    = int'($urandom % (((lim - base + 2) > 1 ? (lim - base + 2) : 2) * 8));
            if (sel == 1) p = 65535 - int'($urandom % 4);
            code = (sel == 2) ? 3 : int'($urandom % 3);
            run(p, code, base, lim, ($urandom % 5) == 0, "R3 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule